// File: doc/BRIEF.md
# Platform System Control Ports and I/O Address Remapper

This block is a byte-wide register file on an ISA-style I/O port bus. It answers one stand-alone port at 0x0092 and a window of 0x52 byte ports starting at 0x0800. Behind these ports sit several pieces of state:

- a soft-reset request;
- a set of fixed board identification values;
- a 4-bit system control field;
- a disk-activity lamp bit;
- two strobes that toggle the lock state of two NVRAM regions;
- a map-type bit.

Any port in the window that has no register reads as 0xFF. A write to such a port is dropped and flagged as an error.

The map-type bit steers a purely combinational translator. It turns an offset inside the CPU's I/O aperture into an ISA port address. In the contiguous map the low 16 bits pass straight through. In the sparse map, bits 4..0 are kept, and the 4 KB page number in bits 26..12 is moved down by seven places, so it lands at bits 19..5.

Bus accesses use a two-state machine. The states are ST_IDLE and ST_RESP, with two transitions:

- ST_IDLE goes to ST_RESP when a request arrives while `io_ready` is high and the address decodes to a port of this block (a register or a hole in the window).
- ST_RESP always returns to ST_IDLE on the next edge.

Register updates take effect at the accepting edge. The response (`io_ack`, `io_rdata`, `io_err` and the lock strobes) is held for the one ST_RESP cycle.

Top module: `plat_sysctl`

## Requirements
- R1: After reset the following hold: `soft_reset` is 0, `disk_light` is 0, the contiguous map is selected, `io_ready` is 1 and `io_ack` is 0. Reads of the system control port (0x081C) and the map-type port (0x0850) return 0x00.
- R2: A request to a decoded port that is accepted in ST_IDLE gives `io_ack` high for exactly the next cycle, with `io_ready` low in that cycle. A request to an address outside 0x0092 and 0x0800..0x0851 is not answered.
- R3: A write to 0x0092 stores the byte, and `soft_reset` follows bit 0 of that byte. A read of 0x0092 returns the stored byte.
- R4: A write to 0x081C keeps bits 3..0 only. A read of 0x081C returns those bits with bits 7..4 as zero.
- R5: The identification ports read fixed values: 0x0800 gives 0xEF, 0x0802 gives 0xAD, 0x0803 gives 0xE0, 0x0818 gives 0x39, and 0x0823 gives 0x03.
- R6: A write to 0x0808 sets `disk_light` to bit 0 of the byte. A read of 0x0808 returns the lamp bit in bit 0.
- R7: A write to 0x0810 pulses `lock1_pulse`, and a write to 0x0812 pulses `lock2_pulse`. Each pulse is high for one cycle, in the ST_RESP cycle, and only when `nvram_present` is 1. Neither strobe fires otherwise.
- R8: A port in 0x0800..0x0851 with no register reads 0xFF. A write to such a port changes no state and raises `io_err` together with `io_ack` for one cycle.
- R9: A write to 0x0850 keeps bit 0 as the map type, where 0 selects contiguous and 1 selects sparse. A read of 0x0850 returns it in bit 0.
- R10: In the contiguous map, `isa_port` equals `cpu_addr[15:0]` zero-extended.
- R11: In the sparse map, `isa_port` equals `(cpu_addr & 0x1F) | ((cpu_addr & 0x7FFF000) >> 7)`.
- R12: A write to an identification port leaves its read value unchanged and does not raise `io_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Port access request |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | ISA port number |
| io_wdata | input | 8 | Write byte |
| io_ready | output | 1 | High in ST_IDLE; a request is taken only then |
| io_ack | output | 1 | One-cycle response for a decoded port |
| io_rdata | output | 8 | Read byte, valid with io_ack |
| io_err | output | 1 | Write to an unassigned port in the window, with io_ack |
| nvram_present | input | 1 | NVRAM fitted; enables the lock strobes |
| soft_reset | output | 1 | Soft-reset request |
| disk_light | output | 1 | Disk-activity lamp |
| lock1_pulse | output | 1 | Toggle lock of NVRAM region 1 |
| lock2_pulse | output | 1 | Toggle lock of NVRAM region 2 |
| cpu_addr | input | 27 | Offset inside the CPU I/O aperture |
| isa_port | output | 20 | Translated ISA port address |

## Verification
Some behaviours are checked by the assertions on every cycle:

- the handshake shape, meaning one acknowledge per accepted decoded request with ready low while it is out;
- the error and lock strobes lasting one cycle, only beside an acknowledge, never together, and the lock strobes only with NVRAM fitted;
- the soft-reset, lamp and map-type state changing only at an accepted write;
- the low five address bits passing through, and the upper bits of the contiguous result staying zero.

Other behaviours can only be shown by the bench's directed scenarios. These are the exact stored widths, the fixed identification bytes, the 0xFF read of a hole, the full sparse page arithmetic across several addresses, and the silence toward addresses outside the decoded range.

// File: rtl/plat_sysctl_pkg.sv
package plat_sysctl_pkg;

    // Port numbers and window layout
    localparam int RST_PORT   = 16'h0092;
    localparam int WIN_BASE   = 16'h0800;
    localparam int WIN_LEN    = 16'h0052;

    // Offsets inside the window
    localparam int OFF_CPUCFG = 8'h00;
    localparam int OFF_FEAT   = 8'h02;
    localparam int OFF_STAT   = 8'h03;
    localparam int OFF_LIGHT  = 8'h08;
    localparam int OFF_LOCK1  = 8'h10;
    localparam int OFF_LOCK2  = 8'h12;
    localparam int OFF_XFEAT  = 8'h18;
    localparam int OFF_SYSCTL = 8'h1C;
    localparam int OFF_L2     = 8'h23;
    localparam int OFF_MAP    = 8'h50;

    // Fixed identification values
    localparam logic [7:0] VAL_CPUCFG = 8'hEF;
    localparam logic [7:0] VAL_FEAT   = 8'hAD;
    localparam logic [7:0] VAL_STAT   = 8'hE0;
    localparam logic [7:0] VAL_XFEAT  = 8'h39;
    localparam logic [7:0] VAL_L2     = 8'h03;
    localparam logic [7:0] VAL_HOLE   = 8'hFF;

    localparam int SYSCTL_W = 4;

    typedef enum logic [3:0] {
        PID_OFF,
        PID_HOLE,
        PID_RST,
        PID_CPUCFG,
        PID_FEAT,
        PID_STAT,
        PID_XFEAT,
        PID_L2,
        PID_LIGHT,
        PID_LOCK1,
        PID_LOCK2,
        PID_SYSCTL,
        PID_MAP
    } port_id_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_state_e;

endpackage

// File: rtl/plat_sysctl_decode.sv
module plat_sysctl_decode
    import plat_sysctl_pkg::*;
#(
    parameter int IO_AW = 16
) (
    input  logic [IO_AW-1:0] io_addr,
    output port_id_e         port_id
);

    localparam logic [IO_AW-1:0] BASE_A = IO_AW'(WIN_BASE);
    localparam logic [IO_AW-1:0] END_A  = IO_AW'(WIN_BASE + WIN_LEN);
    localparam logic [IO_AW-1:0] RST_A  = IO_AW'(RST_PORT);

    logic [IO_AW-1:0] off;
    logic             in_win;

    assign off    = io_addr - BASE_A;
    assign in_win = (io_addr >= BASE_A) && (io_addr < END_A);

    always_comb begin
        port_id = PID_OFF;
        if (io_addr == RST_A) begin
            port_id = PID_RST;
        end else if (in_win) begin
            port_id = PID_HOLE;
            case (off)
                IO_AW'(OFF_CPUCFG): port_id = PID_CPUCFG;
                IO_AW'(OFF_FEAT):   port_id = PID_FEAT;
                IO_AW'(OFF_STAT):   port_id = PID_STAT;
                IO_AW'(OFF_LIGHT):  port_id = PID_LIGHT;
                IO_AW'(OFF_LOCK1):  port_id = PID_LOCK1;
                IO_AW'(OFF_LOCK2):  port_id = PID_LOCK2;
                IO_AW'(OFF_XFEAT):  port_id = PID_XFEAT;
                IO_AW'(OFF_SYSCTL): port_id = PID_SYSCTL;
                IO_AW'(OFF_L2):     port_id = PID_L2;
                IO_AW'(OFF_MAP):    port_id = PID_MAP;
                default:            port_id = PID_HOLE;
            endcase
        end
    end

endmodule

// File: rtl/plat_sysctl_regs.sv
module plat_sysctl_regs
    import plat_sysctl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  port_id_e      port_id,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data,
    output logic          soft_reset,
    output logic          disk_light,
    output logic          map_sparse
);

    logic [DW-1:0]       rst_byte_q;
    logic [SYSCTL_W-1:0] sysctl_q;
    logic                light_q;
    logic                map_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_byte_q <= '0;
            sysctl_q   <= '0;
            light_q    <= 1'b0;
            map_q      <= 1'b0;
        end else if (wr_stb) begin
            unique case (port_id)
                PID_RST:    rst_byte_q <= wdata;
                PID_SYSCTL: sysctl_q   <= wdata[SYSCTL_W-1:0];
                PID_LIGHT:  light_q    <= wdata[0];
                PID_MAP:    map_q      <= wdata[0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (port_id)
            PID_RST:    rd_data = rst_byte_q;
            PID_CPUCFG: rd_data = DW'(VAL_CPUCFG);
            PID_FEAT:   rd_data = DW'(VAL_FEAT);
            PID_STAT:   rd_data = DW'(VAL_STAT);
            PID_XFEAT:  rd_data = DW'(VAL_XFEAT);
            PID_L2:     rd_data = DW'(VAL_L2);
            PID_LIGHT:  rd_data = DW'(light_q);
            PID_LOCK1,
            PID_LOCK2:  rd_data = '0;
            PID_SYSCTL: rd_data = DW'(sysctl_q);
            PID_MAP:    rd_data = DW'(map_q);
            default:    rd_data = DW'(VAL_HOLE);
        endcase
    end

    assign soft_reset = rst_byte_q[0];
    assign disk_light = light_q;
    assign map_sparse = map_q;

endmodule

// File: rtl/plat_sysctl_remap.sv
module plat_sysctl_remap #(
    parameter int CPU_AW    = 27,
    parameter int CONTIG_AW = 16,
    parameter int LOW_BITS  = 5,
    parameter int PAGE_LO   = 12,
    parameter int SHIFT     = 7
) (
    input  logic                      map_sparse,
    input  logic [CPU_AW-1:0]         cpu_addr,
    output logic [CPU_AW-SHIFT-1:0]   isa_port
);

    localparam int ISA_AW  = CPU_AW - SHIFT;
    localparam int PAGE_HI = CPU_AW - 1;
    localparam int PAD     = PAGE_LO - SHIFT;

    logic [ISA_AW-1:0] sparse_a;
    logic [ISA_AW-1:0] contig_a;

    assign sparse_a = ISA_AW'({cpu_addr[PAGE_HI:PAGE_LO], {PAD{1'b0}}})
                    | ISA_AW'(cpu_addr[LOW_BITS-1:0]);
    assign contig_a = ISA_AW'(cpu_addr[CONTIG_AW-1:0]);

    assign isa_port = map_sparse ? sparse_a : contig_a;

endmodule

// File: rtl/plat_sysctl.sv
module plat_sysctl
    import plat_sysctl_pkg::*;
#(
    parameter int IO_AW  = 16,
    parameter int DW     = 8,
    parameter int CPU_AW = 27,
    parameter int SHIFT  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    io_req,
    input  logic                    io_we,
    input  logic [IO_AW-1:0]        io_addr,
    input  logic [DW-1:0]           io_wdata,
    output logic                    io_ready,
    output logic                    io_ack,
    output logic [DW-1:0]           io_rdata,
    output logic                    io_err,
    input  logic                    nvram_present,
    output logic                    soft_reset,
    output logic                    disk_light,
    output logic                    lock1_pulse,
    output logic                    lock2_pulse,
    input  logic [CPU_AW-1:0]       cpu_addr,
    output logic [CPU_AW-SHIFT-1:0] isa_port
);

    bus_state_e    state_q, state_d;
    port_id_e      port_id;
    logic [DW-1:0] rd_data;
    logic          map_sparse;
    logic          accept;
    logic          wr_stb;
    logic [DW-1:0] rdata_q;
    logic          err_q, lk1_q, lk2_q;

    plat_sysctl_decode #(.IO_AW(IO_AW)) u_decode (
        .io_addr (io_addr),
        .port_id (port_id)
    );

    assign accept = io_req && (state_q == ST_IDLE) && (port_id != PID_OFF);
    assign wr_stb = accept && io_we;

    plat_sysctl_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .port_id    (port_id),
        .wdata      (io_wdata),
        .rd_data    (rd_data),
        .soft_reset (soft_reset),
        .disk_light (disk_light),
        .map_sparse (map_sparse)
    );

    plat_sysctl_remap #(.CPU_AW(CPU_AW), .SHIFT(SHIFT)) u_remap (
        .map_sparse (map_sparse),
        .cpu_addr   (cpu_addr),
        .isa_port   (isa_port)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // response registers, loaded at the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
            lk1_q   <= 1'b0;
            lk2_q   <= 1'b0;
        end else if (accept) begin
            rdata_q <= rd_data;
            err_q   <= io_we && (port_id == PID_HOLE);
            lk1_q   <= io_we && (port_id == PID_LOCK1) && nvram_present;
            lk2_q   <= io_we && (port_id == PID_LOCK2) && nvram_present;
        end else begin
            err_q   <= 1'b0;
            lk1_q   <= 1'b0;
            lk2_q   <= 1'b0;
        end
    end

    // outputs from state
    always_comb begin
        io_ready    = 1'b0;
        io_ack      = 1'b0;
        io_rdata    = '0;
        io_err      = 1'b0;
        lock1_pulse = 1'b0;
        lock2_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: io_ready = 1'b1;
            ST_RESP: begin
                io_ack      = 1'b1;
                io_rdata    = rdata_q;
                io_err      = err_q;
                lock1_pulse = lk1_q;
                lock2_pulse = lk2_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/plat_sysctl_chk.sv
module plat_sysctl_chk
    import plat_sysctl_pkg::*;
#(
    parameter int CPU_AW = 27,
    parameter int SHIFT  = 7
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    io_req,
    input logic                    io_we,
    input logic                    io_ready,
    input logic                    io_ack,
    input logic                    io_err,
    input logic                    nvram_present,
    input logic                    soft_reset,
    input logic                    disk_light,
    input logic                    lock1_pulse,
    input logic                    lock2_pulse,
    input logic                    map_sparse,
    input port_id_e                port_id,
    input logic [CPU_AW-1:0]       cpu_addr,
    input logic [CPU_AW-SHIFT-1:0] isa_port
);

    a_r2_ack_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && io_ready && port_id != PID_OFF) |=> io_ack);

    a_r2_ack_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |-> !io_ready);

    a_r2_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |=> !io_ack);

    a_r8_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        io_err |-> io_ack);

    a_r7_lock_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lock1_pulse && lock2_pulse));

    a_r7_lock_needs_nvram: assert property (@(posedge clk) disable iff (!rst_n)
        (lock1_pulse || lock2_pulse) |-> (io_ack && $past(nvram_present)));

    a_r3_reset_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(soft_reset) |-> $past(io_req && io_ready && io_we));

    a_r6_light_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disk_light) |-> $past(io_req && io_ready && io_we));

    a_r9_map_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(map_sparse) |-> $past(io_req && io_ready && io_we));

    a_r11_low_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
        isa_port[4:0] == cpu_addr[4:0]);

    a_r10_contig_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !map_sparse |-> (isa_port[CPU_AW-SHIFT-1:16] == '0));

endmodule

bind plat_sysctl plat_sysctl_chk #(.CPU_AW(CPU_AW), .SHIFT(SHIFT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_req        (io_req),
    .io_we         (io_we),
    .io_ready      (io_ready),
    .io_ack        (io_ack),
    .io_err        (io_err),
    .nvram_present (nvram_present),
    .soft_reset    (soft_reset),
    .disk_light    (disk_light),
    .lock1_pulse   (lock1_pulse),
    .lock2_pulse   (lock2_pulse),
    .map_sparse    (map_sparse),
    .port_id       (port_id),
    .cpu_addr      (cpu_addr),
    .isa_port      (isa_port)
);

// File: tb/tb_plat_sysctl.sv
`timescale 1ns/1ps
module tb_plat_sysctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0;
    logic        io_we = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_ready, io_ack, io_err;
    logic [7:0]  io_rdata;
    logic        nvram_present = 1'b1;
    logic        soft_reset, disk_light, lock1_pulse, lock2_pulse;
    logic [26:0] cpu_addr = '0;
    logic [19:0] isa_port;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic       s_ack, s_rdy, s_err, s_l1, s_l2;
    logic [7:0] s_data;
    logic       n_ack, n_err, n_l1, n_l2;

    always #2.5 clk = ~clk;

    plat_sysctl dut (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_ready(io_ready),
        .io_ack(io_ack), .io_rdata(io_rdata), .io_err(io_err),
        .nvram_present(nvram_present), .soft_reset(soft_reset),
        .disk_light(disk_light), .lock1_pulse(lock1_pulse),
        .lock2_pulse(lock2_pulse), .cpu_addr(cpu_addr), .isa_port(isa_port)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_req = 1'b1; io_we = we; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_req = 1'b0; io_we = 1'b0;
        s_ack = io_ack; s_rdy = io_ready; s_data = io_rdata;
        s_err = io_err; s_l1 = lock1_pulse; s_l2 = lock2_pulse;
        @(negedge clk);
        n_ack = io_ack; n_err = io_err; n_l1 = lock1_pulse; n_l2 = lock2_pulse;
    endtask

    task automatic rd_expect(input string tag, input logic [15:0] a, input logic [7:0] exp);
        access(1'b0, a, 8'h00);
        chk({tag, " ack"}, 32'(s_ack), 32'd1);
        chk({tag, " data"}, 32'(s_data), 32'(exp));
    endtask

    task automatic t_reset_state;
        chk("R1 soft_reset", 32'(soft_reset), 0);
        chk("R1 disk_light", 32'(disk_light), 0);
        chk("R1 io_ready", 32'(io_ready), 1);
        chk("R1 io_ack", 32'(io_ack), 0);
        cpu_addr = 27'h7ABCDEF;
        #1;
        chk("R1 contiguous map", 32'(isa_port), 32'h0CDEF);
        rd_expect("R1 sysctl", 16'h081C, 8'h00);
        rd_expect("R1 maptype", 16'h0850, 8'h00);
    endtask

    task automatic t_handshake;
        access(1'b0, 16'h0800, 8'h00);
        chk("R2 ack", 32'(s_ack), 1);
        chk("R2 ready low", 32'(s_rdy), 0);
        chk("R2 ack one cycle", 32'(n_ack), 0);
        access(1'b0, 16'h0852, 8'h00);
        chk("R2 no ack beyond window", 32'(s_ack), 0);
        access(1'b1, 16'h0093, 8'h01);
        chk("R2 no ack next to reset port", 32'(s_ack), 0);
        chk("R2 unrelated port write ignored", 32'(soft_reset), 0);
    endtask

    task automatic t_ids;
        rd_expect("R5 cpu cfg", 16'h0800, 8'hEF);
        rd_expect("R5 feature", 16'h0802, 8'hAD);
        rd_expect("R5 status", 16'h0803, 8'hE0);
        rd_expect("R5 ext feature", 16'h0818, 8'h39);
        rd_expect("R5 l2", 16'h0823, 8'h03);
        access(1'b1, 16'h0800, 8'h5A);
        chk("R12 no err", 32'(s_err), 0);
        rd_expect("R12 id unchanged", 16'h0800, 8'hEF);
        access(1'b1, 16'h0823, 8'h00);
        rd_expect("R12 l2 unchanged", 16'h0823, 8'h03);
    endtask

    task automatic t_reset_port;
        access(1'b1, 16'h0092, 8'h81);
        chk("R3 reset raised", 32'(soft_reset), 1);
        rd_expect("R3 readback", 16'h0092, 8'h81);
        access(1'b1, 16'h0092, 8'h06);
        chk("R3 reset lowered", 32'(soft_reset), 0);
        rd_expect("R3 readback 2", 16'h0092, 8'h06);
    endtask

    task automatic t_sysctl;
        access(1'b1, 16'h081C, 8'hA7);
        rd_expect("R4 low nibble", 16'h081C, 8'h07);
        access(1'b1, 16'h081C, 8'hF8);
        rd_expect("R4 low nibble 2", 16'h081C, 8'h08);
    endtask

    task automatic t_light;
        access(1'b1, 16'h0808, 8'h01);
        chk("R6 light on", 32'(disk_light), 1);
        rd_expect("R6 light read", 16'h0808, 8'h01);
        access(1'b1, 16'h0808, 8'hFE);
        chk("R6 light off", 32'(disk_light), 0);
    endtask

    task automatic t_lock;
        nvram_present = 1'b1;
        access(1'b1, 16'h0810, 8'h00);
        chk("R7 lock1 pulse", 32'(s_l1), 1);
        chk("R7 lock2 quiet", 32'(s_l2), 0);
        chk("R7 lock1 one cycle", 32'(n_l1), 0);
        access(1'b1, 16'h0812, 8'h00);
        chk("R7 lock2 pulse", 32'(s_l2), 1);
        chk("R7 lock1 quiet", 32'(s_l1), 0);
        chk("R7 lock2 one cycle", 32'(n_l2), 0);
        access(1'b0, 16'h0810, 8'h00);
        chk("R7 no pulse on read", 32'(s_l1), 0);
        nvram_present = 1'b0;
        access(1'b1, 16'h0810, 8'h00);
        chk("R7 suppressed lock1", 32'(s_l1), 0);
        access(1'b1, 16'h0812, 8'h00);
        chk("R7 suppressed lock2", 32'(s_l2), 0);
        nvram_present = 1'b1;
    endtask

    task automatic t_holes;
        rd_expect("R8 hole read", 16'h0801, 8'hFF);
        rd_expect("R8 last hole read", 16'h0851, 8'hFF);
        chk("R8 no err on read", 32'(s_err), 0);
        access(1'b1, 16'h081D, 8'h0F);
        chk("R8 err", 32'(s_err), 1);
        chk("R8 err ack", 32'(s_ack), 1);
        chk("R8 err one cycle", 32'(n_err), 0);
        rd_expect("R8 sysctl untouched", 16'h081C, 8'h08);
        chk("R8 light untouched", 32'(disk_light), 0);
        chk("R8 reset untouched", 32'(soft_reset), 0);
    endtask

    task automatic t_map;
        logic [31:0] a;
        access(1'b1, 16'h0850, 8'h03);
        rd_expect("R9 map read", 16'h0850, 8'h01);
        a = 32'h7FFF01F;
        cpu_addr = a[26:0]; #1;
        chk("R11 sparse all", 32'(isa_port), (a & 32'h1F) | ((a & 32'h7FFF000) >> 7));
        a = 32'h0123FE5;
        cpu_addr = a[26:0]; #1;
        chk("R11 sparse mixed", 32'(isa_port), (a & 32'h1F) | ((a & 32'h7FFF000) >> 7));
        a = 32'h0001FE0;
        cpu_addr = a[26:0]; #1;
        chk("R11 sparse page1", 32'(isa_port), 32'h00020);
        access(1'b1, 16'h0850, 8'hFE);
        rd_expect("R9 map cleared", 16'h0850, 8'h00);
        a = 32'h5A5A5A5;
        cpu_addr = a[26:0]; #1;
        chk("R10 contiguous", 32'(isa_port), a & 32'hFFFF);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++; total++;
                $display("FAIL watchdog expired");
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state;
        t_handshake;
        t_ids;
        t_reset_port;
        t_sysctl;
        t_light;
        t_lock;
        t_holes;
        t_map;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule